// File: doc/BRIEF.md
# Bit-Instruction Operand Address Decoder

This block sits in an instruction front end and turns the bytes of a bit-manipulation instruction into the location of the bit that instruction acts on. Bytes arrive one at a time over a valid/ready handshake. The block recognises two encodings. The general encoding is a fixed opcode byte, then a mode byte that carries a 4-bit addressing mode, then zero to two extension bytes. The short encoding is a single byte that carries a 3-bit bit number, followed by one displacement byte.

When the last byte of an instruction has been taken, the block presents one result for a single cycle. The result is either a register target with a bit index 0–15, or a memory target given as a 13-bit byte address and a 3-bit bit number. It also gives the total instruction length in bytes. The address computation reads the current values of the two address registers and of the static-base and frame-base registers. These values are read in the cycle the result is valid. A first byte that fits neither encoding raises an error pulse instead of a result. So does a mode byte with the wrong upper nibble.

Top module: `bitop_addr_dec`

## Requirements
- R1: A first byte of 0x7E must be followed by a byte whose bits [7:4] are 1000. A first byte that is neither 0x7E nor of the form 0100_0bbb, or a wrong mode byte, gives a one-cycle `err` pulse in the cycle after that byte is taken. No result is produced for it.
- R2: Short form 0100_0bbb plus displacement d: bit address = SB×8 + d×8 + bbb. The length is 2.
- R3: General modes 0000–0101 give a register target with `res_reg_sel` equal to the mode (0 = R0, 1 = R1, 2 = R2, 3 = R3, 4 = A0, 5 = A1). They take one extension byte, and its bits [3:0] are the bit index; bits [7:4] are ignored. The length is 3.
- R4: Modes 0110 (A0) and 0111 (A1) take no extension byte. The register value is the whole bit address. The length is 2.
- R5: Modes 1000/1001 (A0/A1) take one extension byte, and modes 1100/1101 take two, low byte first. In both cases the bit address = extension×8 + register. The length is 3 and 4 respectively.
- R6: Mode 1010 takes one extension byte e: bit address = SB×8 + e, with e zero-extended. Mode 1011: bit address = FB×8 + e, with e sign-extended. The length is 3.
- R7: Mode 1110 takes a two-byte extension x, low byte first: bit address = SB×8 + x. Mode 1111: bit address = x. The length is 4.
- R8: The bit address is 16 bits wide and wraps modulo 2^16. The byte address is bits [15:3] and the bit number is bits [2:0].
- R9: `res_valid` is high for exactly one cycle, the cycle after the last byte is taken. `in_ready` is low in that cycle and in any `err` cycle, and high again in the cycle after.
- R10: An active reset abandons a partly received instruction. The next byte after reset is treated as a first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block can take a byte |
| reg_a0 | input | 16 | Address register 0 value |
| reg_a1 | input | 16 | Address register 1 value |
| reg_sb | input | 16 | Static base register value (byte address) |
| reg_fb | input | 16 | Frame base register value (byte address) |
| res_valid | output | 1 | One-cycle result strobe |
| res_is_reg | output | 1 | Result is a register target |
| res_reg_sel | output | 3 | Register selector for a register target |
| res_bit_idx | output | 4 | Bit index inside the register |
| res_byte_addr | output | 13 | Byte address of a memory target |
| res_bit_num | output | 3 | Bit number inside the addressed byte |
| res_len | output | 3 | Instruction length in bytes |
| err | output | 1 | One-cycle strobe for an unrecognised encoding |

## Verification
The assertions assume that `in_valid` and `in_byte` are known values at every clock edge after reset. They also assume that the four register inputs are held steady while a result is shown, because the memory address is formed from their values in that cycle. The bench drives the handshake and data on falling edges and sets the register values once before decoding starts. Only afterwards does it send any byte, and it samples outputs on falling edges. Inputs therefore never change near the edge that registers them, or in the cycle that reports a result.

// File: rtl/bitdec_pkg.sv
package bitdec_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned BITPOS_W = 3;
  localparam logic [7:0]  OPC_GEN  = 8'h7E;
  localparam logic [3:0]  MODE_HI  = 4'b1000;
  localparam logic [4:0]  SHORT_HI = 5'b01000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MODE,
    ST_EXT0,
    ST_EXT1,
    ST_RESULT,
    ST_FAULT
  } dec_state_t;

  // number of extension bytes a general-form mode consumes
  function automatic logic [1:0] ext_bytes(input logic [3:0] m);
    logic [1:0] n;
    case (m)
      4'b0110, 4'b0111:                   n = 2'd0;
      4'b1100, 4'b1101, 4'b1110, 4'b1111: n = 2'd2;
      default:                            n = 2'd1;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/bitdec_seq.sv
module bitdec_seq
  import bitdec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [BYTE_W-1:0]    in_byte,
  output logic                 in_ready,
  output dec_state_t           state,
  output logic                 is_short,
  output logic [3:0]           mode,
  output logic [BITPOS_W-1:0]  short_bit,
  output logic [BYTE_W-1:0]    ext_lo,
  output logic [BYTE_W-1:0]    ext_hi
);

  dec_state_t              state_n;
  logic                    short_n;
  logic [3:0]              mode_n;
  logic [BITPOS_W-1:0]     sbit_n;
  logic [BYTE_W-1:0]       lo_n, hi_n;
  logic [1:0]              need_q, need_n;
  logic                    accept;

  assign in_ready = (state == ST_IDLE) || (state == ST_MODE) ||
                    (state == ST_EXT0) || (state == ST_EXT1);
  assign accept   = in_valid && in_ready;

  always_comb begin
    state_n = state;
    short_n = is_short;
    mode_n  = mode;
    sbit_n  = short_bit;
    lo_n    = ext_lo;
    hi_n    = ext_hi;
    need_n  = need_q;
    case (state)
      ST_IDLE: if (accept) begin
        if (in_byte == OPC_GEN) begin
          state_n = ST_MODE;
        end else if (in_byte[7:3] == SHORT_HI) begin
          short_n = 1'b1;
          sbit_n  = in_byte[BITPOS_W-1:0];
          need_n  = 2'd1;
          state_n = ST_EXT0;
        end else begin
          state_n = ST_FAULT;
        end
      end
      ST_MODE: if (accept) begin
        if (in_byte[7:4] == MODE_HI) begin
          short_n = 1'b0;
          mode_n  = in_byte[3:0];
          need_n  = ext_bytes(in_byte[3:0]);
          state_n = (ext_bytes(in_byte[3:0]) == 2'd0) ? ST_RESULT : ST_EXT0;
        end else begin
          state_n = ST_FAULT;
        end
      end
      ST_EXT0: if (accept) begin
        lo_n    = in_byte;
        state_n = (need_q == 2'd2) ? ST_EXT1 : ST_RESULT;
      end
      ST_EXT1: if (accept) begin
        hi_n    = in_byte;
        state_n = ST_RESULT;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      is_short  <= 1'b0;
      mode      <= '0;
      short_bit <= '0;
      ext_lo    <= '0;
      ext_hi    <= '0;
      need_q    <= '0;
    end else begin
      state     <= state_n;
      is_short  <= short_n;
      mode      <= mode_n;
      short_bit <= sbit_n;
      ext_lo    <= lo_n;
      ext_hi    <= hi_n;
      need_q    <= need_n;
    end
  end

endmodule

// File: rtl/bitdec_addr.sv
module bitdec_addr
  import bitdec_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned ADDR_W = DATA_W - BITPOS_W,
  localparam int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic                 is_short,
  input  logic [3:0]           mode,
  input  logic [BITPOS_W-1:0]  short_bit,
  input  logic [BYTE_W-1:0]    ext_lo,
  input  logic [BYTE_W-1:0]    ext_hi,
  input  logic [DATA_W-1:0]    reg_a0,
  input  logic [DATA_W-1:0]    reg_a1,
  input  logic [DATA_W-1:0]    reg_sb,
  input  logic [DATA_W-1:0]    reg_fb,
  output logic                 is_reg,
  output logic [2:0]           reg_sel,
  output logic [IDX_W-1:0]     bit_idx,
  output logic [ADDR_W-1:0]    byte_addr,
  output logic [BITPOS_W-1:0]  bit_num,
  output logic [2:0]           len
);

  logic [DATA_W-1:0] ext_w, ext_z, ext_s, an, sb_bits, fb_bits, bit_addr;

  assign ext_z   = DATA_W'(ext_lo);
  assign ext_s   = {{(DATA_W-BYTE_W){ext_lo[BYTE_W-1]}}, ext_lo};
  assign ext_w   = DATA_W'({ext_hi, ext_lo});
  assign an      = mode[0] ? reg_a1 : reg_a0;
  assign sb_bits = reg_sb << BITPOS_W;
  assign fb_bits = reg_fb << BITPOS_W;

  always_comb begin
    bit_addr = '0;
    if (is_short) begin
      bit_addr = sb_bits + DATA_W'({ext_lo, short_bit});
    end else begin
      case (mode)
        4'b0110, 4'b0111: bit_addr = an;
        4'b1000, 4'b1001: bit_addr = (ext_z << BITPOS_W) + an;
        4'b1100, 4'b1101: bit_addr = (ext_w << BITPOS_W) + an;
        4'b1010:          bit_addr = sb_bits + ext_z;
        4'b1011:          bit_addr = fb_bits + ext_s;
        4'b1110:          bit_addr = sb_bits + ext_w;
        4'b1111:          bit_addr = ext_w;
        default:          bit_addr = '0;
      endcase
    end
  end

  assign is_reg    = !is_short && (mode < 4'd6);
  assign reg_sel   = mode[2:0];
  assign bit_idx   = ext_lo[IDX_W-1:0];
  assign byte_addr = bit_addr[DATA_W-1:BITPOS_W];
  assign bit_num   = bit_addr[BITPOS_W-1:0];
  assign len       = is_short ? 3'd2 : (3'd2 + {1'b0, ext_bytes(mode)});

endmodule

// File: rtl/bitop_addr_dec.sv
module bitop_addr_dec
  import bitdec_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned ADDR_W = DATA_W - BITPOS_W,
  localparam int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [7:0]           in_byte,
  output logic                 in_ready,
  input  logic [DATA_W-1:0]    reg_a0,
  input  logic [DATA_W-1:0]    reg_a1,
  input  logic [DATA_W-1:0]    reg_sb,
  input  logic [DATA_W-1:0]    reg_fb,
  output logic                 res_valid,
  output logic                 res_is_reg,
  output logic [2:0]           res_reg_sel,
  output logic [IDX_W-1:0]     res_bit_idx,
  output logic [ADDR_W-1:0]    res_byte_addr,
  output logic [BITPOS_W-1:0]  res_bit_num,
  output logic [2:0]           res_len,
  output logic                 err
);

  dec_state_t            state;
  logic                  is_short;
  logic [3:0]            mode;
  logic [BITPOS_W-1:0]   short_bit;
  logic [7:0]            ext_lo, ext_hi;

  bitdec_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .in_ready  (in_ready),
    .state     (state),
    .is_short  (is_short),
    .mode      (mode),
    .short_bit (short_bit),
    .ext_lo    (ext_lo),
    .ext_hi    (ext_hi)
  );

  bitdec_addr #(.DATA_W(DATA_W)) u_addr (
    .is_short  (is_short),
    .mode      (mode),
    .short_bit (short_bit),
    .ext_lo    (ext_lo),
    .ext_hi    (ext_hi),
    .reg_a0    (reg_a0),
    .reg_a1    (reg_a1),
    .reg_sb    (reg_sb),
    .reg_fb    (reg_fb),
    .is_reg    (res_is_reg),
    .reg_sel   (res_reg_sel),
    .bit_idx   (res_bit_idx),
    .byte_addr (res_byte_addr),
    .bit_num   (res_bit_num),
    .len       (res_len)
  );

  assign res_valid = (state == ST_RESULT);
  assign err       = (state == ST_FAULT);

endmodule

// File: rtl/bitdec_chk.sv
module bitdec_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       res_valid,
  input logic       res_is_reg,
  input logic [2:0] res_reg_sel,
  input logic [2:0] res_len,
  input logic       err
);

  // R9: result strobe lasts one cycle
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R9: no byte taken while a result or fault is shown
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || err) |-> !in_ready);

  // R9: ready again right after
  p_ready_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || err) |=> in_ready);

  // R1: a fault never carries a result
  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && err));

  // R3: register targets use one extension byte and a legal selector
  p_reglen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_is_reg) |-> (res_len == 3'd3 && res_reg_sel <= 3'd5));

  // R5: every length lies between two and four bytes
  p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_len >= 3'd2 && res_len <= 3'd4));

endmodule

bind bitop_addr_dec bitdec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .res_valid   (res_valid),
  .res_is_reg  (res_is_reg),
  .res_reg_sel (res_reg_sel),
  .res_len     (res_len),
  .err         (err)
);

// File: tb/bitop_addr_dec_test.sv
module bitop_addr_dec_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready;
  logic [15:0] reg_a0 = 16'h1234, reg_a1 = 16'h0013;
  logic [15:0] reg_sb = 16'h0400, reg_fb = 16'h0800;
  logic        res_valid, res_is_reg, err;
  logic [2:0]  res_reg_sel, res_bit_num, res_len;
  logic [3:0]  res_bit_idx;
  logic [12:0] res_byte_addr;

  int n_cmp = 0;
  int n_bad = 0;

  // captured outcome
  logic        g_valid, g_err, g_isreg;
  logic [2:0]  g_sel, g_bit, g_len;
  logic [3:0]  g_idx;
  logic [12:0] g_addr;

  always #5 clk = ~clk;

  bitop_addr_dec uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .reg_a0(reg_a0), .reg_a1(reg_a1),
    .reg_sb(reg_sb), .reg_fb(reg_fb), .res_valid(res_valid),
    .res_is_reg(res_is_reg), .res_reg_sel(res_reg_sel),
    .res_bit_idx(res_bit_idx), .res_byte_addr(res_byte_addr),
    .res_bit_num(res_bit_num), .res_len(res_len), .err(err)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  // wait for result or fault, sampling on falling edges
  task automatic collect();
    g_valid = 1'b0; g_err = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (res_valid || err) begin
        g_valid = res_valid; g_err = err; g_isreg = res_is_reg;
        g_sel = res_reg_sel; g_idx = res_bit_idx; g_addr = res_byte_addr;
        g_bit = res_bit_num; g_len = res_len;
        check("R9 ready low with result", int'(in_ready), 0);
        @(negedge clk);
        check("R9 strobe one cycle", int'(res_valid || err), 0);
        check("R9 ready restored", int'(in_ready), 1);
        break;
      end
    end
  endtask

  task automatic expect_mem(input string tag, input logic [12:0] a,
                            input logic [2:0] b, input logic [2:0] l);
    collect();
    check({tag, " valid"}, int'(g_valid), 1);
    check({tag, " is_reg"}, int'(g_isreg), 0);
    check({tag, " byte_addr"}, int'(g_addr), int'(a));
    check({tag, " bit_num"}, int'(g_bit), int'(b));
    check({tag, " len"}, int'(g_len), int'(l));
  endtask

  task automatic t_reset_state();
    check("R10 reset ready", int'(in_ready), 1);
    check("R10 reset no result", int'(res_valid), 0);
    check("R10 reset no err", int'(err), 0);
  endtask

  task automatic t_reg_target();
    put(8'h7E); put(8'h82); put(8'hAB);
    collect();
    check("R3 valid", int'(g_valid), 1);
    check("R3 is_reg", int'(g_isreg), 1);
    check("R3 sel", int'(g_sel), 2);
    check("R3 idx upper nibble ignored", int'(g_idx), 4'hB);
    check("R3 len", int'(g_len), 3);
    put(8'h7E); put(8'h85); put(8'h0F);
    collect();
    check("R3 sel A1", int'(g_sel), 5);
    check("R3 idx 15", int'(g_idx), 15);
  endtask

  task automatic t_short();
    put(8'h45); put(8'h03);
    expect_mem("R2 short", 13'h403, 3'd5, 3'd2);
  endtask

  task automatic t_indirect();
    put(8'h7E); put(8'h86);
    expect_mem("R4 A0 bit address", 13'h246, 3'd4, 3'd2);
    put(8'h7E); put(8'h87);
    expect_mem("R4 A1 bit address", 13'h002, 3'd3, 3'd2);
  endtask

  task automatic t_based_index();
    put(8'h7E); put(8'h89); put(8'h10);
    expect_mem("R5 base8 A1", 13'h012, 3'd3, 3'd3);
    put(8'h7E); put(8'h8D); put(8'h00); put(8'h01);
    expect_mem("R5 base16 A1 low first", 13'h102, 3'd3, 3'd4);
  endtask

  task automatic t_sb_fb();
    put(8'h7E); put(8'h8A); put(8'h29);
    expect_mem("R6 SB unsigned", 13'h405, 3'd1, 3'd3);
    put(8'h7E); put(8'h8B); put(8'hF8);
    expect_mem("R6 FB signed", 13'h7FF, 3'd0, 3'd3);
  endtask

  task automatic t_long();
    put(8'h7E); put(8'h8E); put(8'h0A); put(8'h01);
    expect_mem("R7 SB 16-bit", 13'h421, 3'd2, 3'd4);
    put(8'h7E); put(8'h8F); put(8'hFF); put(8'hFF);
    expect_mem("R7 absolute top", 13'h1FFF, 3'd7, 3'd4);
  endtask

  task automatic t_wrap();
    // 0x1FFF*8 + 0x1234 = 0x1122C, kept to 0x122C
    put(8'h7E); put(8'h8C); put(8'hFF); put(8'h1F);
    expect_mem("R8 wrap", 13'h245, 3'd4, 3'd4);
  endtask

  task automatic t_errors();
    put(8'h55);
    collect();
    check("R1 bad first byte err", int'(g_err), 1);
    check("R1 bad first byte no result", int'(g_valid), 0);
    put(8'h7E); put(8'h90);
    collect();
    check("R1 bad mode byte err", int'(g_err), 1);
    check("R1 bad mode byte no result", int'(g_valid), 0);
    put(8'h48); // 0100_1xxx is not short form
    collect();
    check("R1 0x48 err", int'(g_err), 1);
  endtask

  task automatic t_reset_midway();
    put(8'h7E);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    put(8'h45); put(8'h03);
    expect_mem("R10 partial decode dropped", 13'h403, 3'd5, 3'd2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog got=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_reg_target();
    t_short();
    t_indirect();
    t_based_index();
    t_sb_fb();
    t_long();
    t_wrap();
    t_errors();
    t_reset_midway();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule